// File: doc/BRIEF.md
# Dual-Lane Serial Maintenance Link

This block joins two duplexed control units over a short point-to-point serial link. The transmitter takes a frame from the local side through a valid/ready handshake. It sends the frame on two data lanes, a high lane and a low lane, together with a forwarded bit clock. The receiver runs on the bit clock that arrives from the far end, rebuilds the frame and presents it to its own local side with a one-cycle valid strobe.

A frame always opens with an 8-bit code. Bit 7 of the code announces a payload. When bit 7 is set, 32 data bits and 4 odd parity bits follow, one parity bit per byte. The high half of the frame rides on the high lane and the low half on the low lane. The local side works with even parity. The block inverts the parity bits on the way out and inverts them back on the way in. The receiver checks each byte against odd parity and flags it on failure.

A separate request line carries the stop-and-switch demand, which asks the far unit to go on-line. The sending side drives it as a registered level. The receiving side passes it through a two-flop synchronizer and turns each rising edge into a single-cycle pulse.

Top module: `duo_lane_link`

## Requirements
- R1: The transmitter always sends code bit 3 as 1, because that bit is the leading bit of the low lane and marks the start of a frame. The receiver reports the code it received, which is the local code with bit 3 set.
- R2: A code with bit 7 clear gives a short frame of 4 bit times per lane. For such a frame the receiver reports has-data 0 and reports data, parity and error flags as all zero.
- R3: A code with bit 7 set gives a long frame of 22 bit times per lane, and the receiver delivers the 32 data bits unchanged.
- R4: Each lane is sent MSB first. The high lane carries code[7:4], then data[31:16], then the link parity bits of bytes 3 and 2. The low lane carries code[3:0], then data[15:0], then the link parity bits of bytes 1 and 0. Byte i is data[8i+7:8i].
- R5: Each link parity bit is the inverse of the parity bit supplied locally for the same byte, which turns even parity into odd parity.
- R6: Error flag i is 1 exactly when byte i and its received link parity bit together hold an even number of ones.
- R7: The receiver's parity output gives each received link parity bit inverted, so it is back in the local even sense.
- R8: The receive valid strobe rises on the rx clock edge that samples the last bit of a frame and lasts exactly one rx clock cycle.
- R9: The forwarded clock toggles on every clk edge, and the lanes change only on edges where it falls. Between frames both lanes are low and tx_ready equals the forwarded clock, so a frame is accepted only on a bit boundary.
- R10: A rising edge on the incoming request line gives a one-clk pulse on sw_pulse_o in the third clk cycle after the change. A falling edge gives no pulse.
- R11: sw_line_o copies sw_req_i one clk edge later.
- R12: While reset is held, both lanes, the forwarded clock, tx_ready, rx_valid_o, sw_line_o and sw_pulse_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, two edges per bit time |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_valid_i | input | 1 | Frame offered for sending |
| tx_ready_o | output | 1 | Transmitter idle and at a bit boundary |
| tx_code_i | input | 8 | Frame code; bit 7 requests a payload |
| tx_data_i | input | 32 | Payload |
| tx_par_i | input | 4 | Local (even) parity, one bit per byte |
| ln_hi_o | output | 1 | Outgoing high lane |
| ln_lo_o | output | 1 | Outgoing low lane |
| ln_clk_o | output | 1 | Forwarded bit clock |
| rx_clk_i | input | 1 | Bit clock received from the far end |
| ln_hi_i | input | 1 | Incoming high lane |
| ln_lo_i | input | 1 | Incoming low lane |
| rx_valid_o | output | 1 | Received frame strobe (rx clock domain) |
| rx_code_o | output | 8 | Received code |
| rx_has_data_o | output | 1 | Received frame carried a payload |
| rx_data_o | output | 32 | Received payload |
| rx_par_o | output | 4 | Received parity in the local sense |
| rx_perr_o | output | 4 | Per-byte odd-parity failure |
| sw_req_i | input | 1 | Local stop-and-switch request level |
| sw_line_o | output | 1 | Outgoing request line |
| sw_line_i | input | 1 | Incoming request line |
| sw_pulse_o | output | 1 | Stop-and-switch event, one clk cycle |

## Verification
A frame accepted at a clk edge puts its first bit on the lanes at that same edge. Each later bit follows two clk edges after the one before it. The bench samples each lane bit at the falling clk edge in the second half of its bit time, while the forwarded clock is high. The receive results of bit n-1 appear on the rising forwarded-clock edge that samples that bit, so the bench reads rx_valid_o and all rx fields at the same falling edge as the final lane bit. It expects rx_valid_o to be low one bit time before and one bit time after. For the request line, sw_line_o is checked one clk edge after sw_req_i changes. With the lines looped back, the pulse is checked to be absent at the falling edges after clk edges one and two, present after edge three and gone after edge four.

// File: rtl/duo_lane_pkg.sv
package duo_lane_pkg;
  parameter int CODE_W = 8;
  parameter int DATA_W = 32;
  parameter int BYTE_W = 8;
  localparam int CODE_H = CODE_W / 2;
  localparam int DATA_H = DATA_W / 2;
  localparam int PAR_W  = DATA_W / BYTE_W;
  localparam int PAR_H  = PAR_W / 2;
  localparam int LANE_W = CODE_H + DATA_H + PAR_H;
  localparam int CNT_W  = $clog2(LANE_W);
  localparam int FLAG_BIT = CODE_W - 1;
  localparam int MARK_BIT = CODE_H - 1;

  // Concatenate one lane's share of a frame, first bit at the MSB.
  function automatic logic [LANE_W-1:0] lane_pack(
    input logic [CODE_H-1:0] c,
    input logic [DATA_H-1:0] d,
    input logic [PAR_H-1:0]  p);
    return {c, d, p};
  endfunction

  // Per-byte odd-parity failure: set when byte plus bit has even weight.
  function automatic logic [PAR_W-1:0] odd_fail(
    input logic [DATA_W-1:0] d,
    input logic [PAR_W-1:0]  p);
    logic [PAR_W-1:0] f;
    for (int i = 0; i < PAR_W; i++)
      f[i] = ~(^{d[i*BYTE_W +: BYTE_W], p[i]});
    return f;
  endfunction
endpackage

// File: rtl/duo_lane_tx.sv
module duo_lane_tx
  import duo_lane_pkg::*;
#(
  parameter bit LOCAL_EVEN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [CODE_W-1:0] code_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [PAR_W-1:0]  par_i,
  output logic              hi_o,
  output logic              lo_o,
  output logic              sclk_o,
  output logic              bit_edge_o
);
  localparam logic [CNT_W-1:0] REM_SHORT = CNT_W'(CODE_H - 1);
  localparam logic [CNT_W-1:0] REM_LONG  = CNT_W'(LANE_W - 1);

  logic              sclk_q, busy_q;
  logic [LANE_W-1:0] hi_sr, lo_sr;
  logic [CNT_W-1:0]  rem_q;
  logic [CODE_W-1:0] code_m;
  logic [PAR_W-1:0]  link_par;
  logic              accept;

  assign code_m     = code_i | (CODE_W'(1) << MARK_BIT);
  assign bit_edge_o = sclk_q;
  assign ready_o    = !busy_q && sclk_q;
  assign accept     = valid_i && ready_o;

  generate
    if (LOCAL_EVEN) begin : g_flip
      assign link_par = ~par_i;
    end else begin : g_pass
      assign link_par = par_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      busy_q <= 1'b0;
      hi_sr  <= '0;
      lo_sr  <= '0;
      rem_q  <= '0;
    end else begin
      sclk_q <= ~sclk_q;
      if (sclk_q) begin
        if (accept) begin
          busy_q <= 1'b1;
          hi_sr  <= lane_pack(code_m[CODE_W-1:CODE_H], data_i[DATA_W-1:DATA_H],
                              link_par[PAR_W-1:PAR_H]);
          lo_sr  <= lane_pack(code_m[CODE_H-1:0], data_i[DATA_H-1:0],
                              link_par[PAR_H-1:0]);
          rem_q  <= code_m[FLAG_BIT] ? REM_LONG : REM_SHORT;
        end else if (busy_q) begin
          if (rem_q == '0) begin
            busy_q <= 1'b0;
            hi_sr  <= '0;
            lo_sr  <= '0;
          end else begin
            hi_sr <= {hi_sr[LANE_W-2:0], 1'b0};
            lo_sr <= {lo_sr[LANE_W-2:0], 1'b0};
            rem_q <= rem_q - 1'b1;
          end
        end
      end
    end
  end

  assign hi_o   = hi_sr[LANE_W-1];
  assign lo_o   = lo_sr[LANE_W-1];
  assign sclk_o = sclk_q;
endmodule

// File: rtl/duo_lane_rx.sv
module duo_lane_rx
  import duo_lane_pkg::*;
#(
  parameter bit LOCAL_EVEN = 1'b1
) (
  input  logic              rx_clk,
  input  logic              rst_n,
  input  logic              hi_i,
  input  logic              lo_i,
  output logic              valid_o,
  output logic [CODE_W-1:0] code_o,
  output logic              has_o,
  output logic [DATA_W-1:0] data_o,
  output logic [PAR_W-1:0]  par_o,
  output logic [PAR_W-1:0]  perr_o,
  output logic              last_bit_o
);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(CODE_H - 1);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(LANE_W - 1);

  logic              active_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [LANE_W-1:0] hsr, lsr, h_nx, l_nx;
  logic              long_end, short_end;
  logic [DATA_W-1:0] w_data;
  logic [PAR_W-1:0]  w_lpar;

  assign h_nx      = {hsr[LANE_W-2:0], hi_i};
  assign l_nx      = {lsr[LANE_W-2:0], lo_i};
  assign short_end = active_q && cnt_q == LAST_SHORT && !h_nx[CODE_H-1];
  assign long_end  = active_q && cnt_q == LAST_LONG;
  assign last_bit_o = short_end || long_end;
  assign w_data    = {h_nx[PAR_H +: DATA_H], l_nx[PAR_H +: DATA_H]};
  assign w_lpar    = {h_nx[PAR_H-1:0], l_nx[PAR_H-1:0]};

  always_ff @(posedge rx_clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      hsr      <= '0;
      lsr      <= '0;
      valid_o  <= 1'b0;
      code_o   <= '0;
      has_o    <= 1'b0;
      data_o   <= '0;
      par_o    <= '0;
      perr_o   <= '0;
    end else begin
      valid_o <= last_bit_o;
      if (!active_q) begin
        if (lo_i) begin
          active_q <= 1'b1;
          cnt_q    <= CNT_W'(1);
          hsr      <= {{(LANE_W-1){1'b0}}, hi_i};
          lsr      <= {{(LANE_W-1){1'b0}}, lo_i};
        end
      end else begin
        hsr   <= h_nx;
        lsr   <= l_nx;
        cnt_q <= cnt_q + 1'b1;
        if (last_bit_o) active_q <= 1'b0;
      end
      if (short_end) begin
        code_o <= {h_nx[CODE_H-1:0], l_nx[CODE_H-1:0]};
        has_o  <= 1'b0;
        data_o <= '0;
        par_o  <= '0;
        perr_o <= '0;
      end else if (long_end) begin
        code_o <= {h_nx[LANE_W-1 -: CODE_H], l_nx[LANE_W-1 -: CODE_H]};
        has_o  <= 1'b1;
        data_o <= w_data;
        par_o  <= LOCAL_EVEN ? ~w_lpar : w_lpar;
        perr_o <= odd_fail(w_data, w_lpar);
      end
    end
  end
endmodule

// File: rtl/duo_lane_swsync.sv
module duo_lane_swsync (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic line_o,
  input  logic line_i,
  output logic pulse_o
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_o <= 1'b0;
      s1     <= 1'b0;
      s2     <= 1'b0;
      s3     <= 1'b0;
    end else begin
      line_o <= req_i;
      s1     <= line_i;
      s2     <= s1;
      s3     <= s2;
    end
  end

  assign pulse_o = s2 && !s3;
endmodule

// File: rtl/duo_lane_link.sv
module duo_lane_link
  import duo_lane_pkg::*;
#(
  parameter bit LOCAL_EVEN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic [CODE_W-1:0] tx_code_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic [PAR_W-1:0]  tx_par_i,
  output logic              ln_hi_o,
  output logic              ln_lo_o,
  output logic              ln_clk_o,
  input  logic              rx_clk_i,
  input  logic              ln_hi_i,
  input  logic              ln_lo_i,
  output logic              rx_valid_o,
  output logic [CODE_W-1:0] rx_code_o,
  output logic              rx_has_data_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic [PAR_W-1:0]  rx_par_o,
  output logic [PAR_W-1:0]  rx_perr_o,
  input  logic              sw_req_i,
  output logic              sw_line_o,
  input  logic              sw_line_i,
  output logic              sw_pulse_o
);
  logic tx_bit_edge;
  logic rx_last_bit;

  duo_lane_tx #(.LOCAL_EVEN(LOCAL_EVEN)) u_tx (
    .clk(clk), .rst_n(rst_n), .valid_i(tx_valid_i), .ready_o(tx_ready_o),
    .code_i(tx_code_i), .data_i(tx_data_i), .par_i(tx_par_i),
    .hi_o(ln_hi_o), .lo_o(ln_lo_o), .sclk_o(ln_clk_o), .bit_edge_o(tx_bit_edge));

  duo_lane_rx #(.LOCAL_EVEN(LOCAL_EVEN)) u_rx (
    .rx_clk(rx_clk_i), .rst_n(rst_n), .hi_i(ln_hi_i), .lo_i(ln_lo_i),
    .valid_o(rx_valid_o), .code_o(rx_code_o), .has_o(rx_has_data_o),
    .data_o(rx_data_o), .par_o(rx_par_o), .perr_o(rx_perr_o),
    .last_bit_o(rx_last_bit));

  duo_lane_swsync u_sw (
    .clk(clk), .rst_n(rst_n), .req_i(sw_req_i), .line_o(sw_line_o),
    .line_i(sw_line_i), .pulse_o(sw_pulse_o));
endmodule

// File: rtl/duo_lane_chk.sv
module duo_lane_chk (
  input logic        clk,
  input logic        rx_clk,
  input logic        rst_n,
  input logic        tx_ready,
  input logic        bit_edge,
  input logic        hi,
  input logic        lo,
  input logic        rx_valid,
  input logic        rx_last,
  input logic        rx_has,
  input logic [7:0]  rx_code,
  input logic [31:0] rx_data,
  input logic [3:0]  rx_perr,
  input logic        sw_req,
  input logic        sw_line,
  input logic        sw_pulse
);
  // R8
  valid_single_chk: assert property (@(posedge rx_clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R8
  valid_follows_last_chk: assert property (@(posedge rx_clk) disable iff (!rst_n)
    rx_last |=> rx_valid);
  // R2
  short_zero_chk: assert property (@(posedge rx_clk) disable iff (!rst_n)
    (rx_valid && !rx_has) |-> (rx_data == '0 && rx_perr == '0));
  // R3
  long_flag_chk: assert property (@(posedge rx_clk) disable iff (!rst_n)
    (rx_valid && rx_has) |-> rx_code[7]);
  // R1
  marker_chk: assert property (@(posedge rx_clk) disable iff (!rst_n)
    rx_valid |-> rx_code[3]);
  // R9
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (!hi && !lo));
  // R9
  lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_edge |=> $stable({hi, lo}));
  // R10
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_pulse |=> !sw_pulse);
  // R11
  line_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req |=> sw_line);
endmodule

bind duo_lane_link duo_lane_chk u_chk (
  .clk(clk), .rx_clk(rx_clk_i), .rst_n(rst_n), .tx_ready(tx_ready_o),
  .bit_edge(tx_bit_edge), .hi(ln_hi_o), .lo(ln_lo_o), .rx_valid(rx_valid_o),
  .rx_last(rx_last_bit), .rx_has(rx_has_data_o), .rx_code(rx_code_o),
  .rx_data(rx_data_o), .rx_perr(rx_perr_o), .sw_req(sw_req_i),
  .sw_line(sw_line_o), .sw_pulse(sw_pulse_o));

// File: tb/duo_lane_link_test.sv
module duo_lane_link_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_valid = 1'b0;
  logic [7:0]  tx_code = '0;
  logic [31:0] tx_data = '0;
  logic [3:0]  tx_par = '0;
  logic sw_req = 1'b0;
  logic tx_ready, hi, lo, lclk, rx_valid, rx_has, sw_line, sw_pulse;
  logic [7:0]  rx_code;
  logic [31:0] rx_data;
  logic [3:0]  rx_par, rx_perr;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  duo_lane_link uut (
    .clk(clk), .rst_n(rst_n), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .tx_code_i(tx_code), .tx_data_i(tx_data), .tx_par_i(tx_par),
    .ln_hi_o(hi), .ln_lo_o(lo), .ln_clk_o(lclk),
    .rx_clk_i(lclk), .ln_hi_i(hi), .ln_lo_i(lo),
    .rx_valid_o(rx_valid), .rx_code_o(rx_code), .rx_has_data_o(rx_has),
    .rx_data_o(rx_data), .rx_par_o(rx_par), .rx_perr_o(rx_perr),
    .sw_req_i(sw_req), .sw_line_o(sw_line), .sw_line_i(sw_line),
    .sw_pulse_o(sw_pulse));

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_bit();
    do @(negedge clk); while (!lclk);
  endtask

  function automatic logic [3:0] even_par(input logic [31:0] d);
    logic [3:0] p;
    for (int i = 0; i < 4; i++) p[i] = ^d[i*8 +: 8];
    return p;
  endfunction

  task automatic send(input logic [7:0] code, input logic [31:0] data,
                      input logic [3:0] corrupt);
    logic [7:0]  ec;
    logic [3:0]  lp, pl;
    logic [21:0] eh, el;
    int n;
    ec = code | 8'h08;
    pl = even_par(data) ^ corrupt;
    lp = ~pl;
    eh = {ec[7:4], data[31:16], lp[3], lp[2]};
    el = {ec[3:0], data[15:0], lp[1], lp[0]};
    n  = ec[7] ? 22 : 4;
    do @(negedge clk); while (!tx_ready);
    tx_valid = 1'b1; tx_code = code; tx_data = data; tx_par = pl;
    @(negedge clk);
    tx_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      wait_bit();
      // R4 lane order, R5 parity positions
      check(hi == eh[21-k], (k >= 20) ? "R5" : "R4", 64'(hi), 64'(eh[21-k]));
      check(lo == el[21-k], (k >= 20) ? "R5" : "R4", 64'(lo), 64'(el[21-k]));
      if (k == n - 2) check(rx_valid == 1'b0, "R8", 64'(rx_valid), 64'd0);
    end
    check(rx_valid == 1'b1, "R8", 64'(rx_valid), 64'd1);
    check(rx_code == ec, "R1", 64'(rx_code), 64'(ec));
    check(rx_has == ec[7], ec[7] ? "R3" : "R2", 64'(rx_has), 64'(ec[7]));
    check(rx_data == (ec[7] ? data : 32'd0), ec[7] ? "R3" : "R2",
          64'(rx_data), 64'(ec[7] ? data : 32'd0));
    check(rx_perr == (ec[7] ? corrupt : 4'd0), ec[7] ? "R6" : "R2",
          64'(rx_perr), 64'(ec[7] ? corrupt : 4'd0));
    check(rx_par == (ec[7] ? pl : 4'd0), ec[7] ? "R7" : "R2",
          64'(rx_par), 64'(ec[7] ? pl : 4'd0));
    wait_bit();
    check(rx_valid == 1'b0, "R8", 64'(rx_valid), 64'd0);
    check({hi, lo} == 2'b00, "R9", 64'({hi, lo}), 64'd0);
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      // R12 reset state
      check({hi, lo, lclk, tx_ready, rx_valid, sw_line, sw_pulse} == 7'd0, "R12",
            64'({hi, lo, lclk, tx_ready, rx_valid, sw_line, sw_pulse}), 64'd0);
    end
    rst_n = 1'b1;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      // R9 idle: ready tracks forwarded clock, lanes low
      check(tx_ready == lclk, "R9", 64'(tx_ready), 64'(lclk));
      check({hi, lo} == 2'b00, "R9", 64'({hi, lo}), 64'd0);
    end
    for (int c = 0; c < 256; c++) begin
      logic [31:0] d;
      d = 32'(c) * 32'h9E3779B1 + 32'h0135_79BD;
      send(8'(c), d, 4'(c >> 2));
    end
    for (int b = 0; b < 256; b++)
      send(8'h80 | 8'(b & 8'h77), {4{8'(b)}}, 4'(b));
    // R10, R11 stop-and-switch path
    @(negedge clk);
    sw_req = 1'b1;
    @(negedge clk);
    check(sw_line == 1'b1, "R11", 64'(sw_line), 64'd1);
    check(sw_pulse == 1'b0, "R10", 64'(sw_pulse), 64'd0);
    @(negedge clk);
    check(sw_pulse == 1'b0, "R10", 64'(sw_pulse), 64'd0);
    @(negedge clk);
    check(sw_pulse == 1'b1, "R10", 64'(sw_pulse), 64'd1);
    @(negedge clk);
    check(sw_pulse == 1'b0, "R10", 64'(sw_pulse), 64'd0);
    sw_req = 1'b0;
    @(negedge clk);
    check(sw_line == 1'b0, "R11", 64'(sw_line), 64'd0);
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      check(sw_pulse == 1'b0, "R10", 64'(sw_pulse), 64'd0);
    end
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule